// File: doc/BRIEF.md
# Floppy Controller Command and Result Sequencer

This block is the host-facing side of a floppy disk controller. It handles every command as three phases. In the command phase the host writes an opcode and then its parameter bytes. In the execution phase an engine does the work, while the host sees the controller as busy. In the result phase the host reads back status bytes. Two status flags pace the host: a ready flag and a direction flag. The host writes a byte only when ready is high and direction is low. It reads a byte only when both are high.

The first byte written selects an entry in a fixed command table. That entry gives the number of parameter bytes, the number of result bytes, and whether the execution engine is used. Parameter bytes are collected in order and handed to the engine together with the opcode and a one-cycle start pulse. When the engine reports completion, the block latches the engine's result bytes and presents them one at a time. Commands with no result bytes return straight to the command phase. Commands that return a constant byte skip the engine entirely.

Top module: `fdc_phase_seq`

## Requirements
- R1: After reset, rqm is 1, dio is 0 and eng_start is 0.
- R2: In the command phase (rqm=1, dio=0), a host_wr stores host_wdata as the opcode or as the next parameter byte. A host_rd in this phase changes nothing.
- R3: An opcode whose low five bits are 00110 is a read command whatever bits 7, 6 and 5 hold. It takes 8 parameter bytes and returns 7 engine result bytes. Parameter byte k appears on eng_params[8k+7:8k], and result byte k is taken from eng_results[8k+7:8k].
- R4: Opcode 0x10 takes no parameters, never pulses eng_start, and returns the single byte 0x90.
- R5: Opcode 0x08 takes no parameters, pulses eng_start, and returns 2 engine result bytes.
- R6: The following opcodes start the engine after their last parameter byte and have no result phase: 0x03 (2 parameters), 0x0F (2), 0x07 (1), 0x13 (3), and 0x8F or 0xCF (2). After eng_done the block goes straight back to the command phase.
- R7: Any opcode not named in R3 to R6 takes no parameters, never pulses eng_start, and returns the single byte 0x80.
- R8: eng_start is a single-cycle pulse in the cycle after the last command byte is accepted. From that cycle until eng_done, rqm is 0 and host writes have no effect.
- R9: In the result phase, rqm=1 and dio=1, and host_rdata shows the current result byte. Each host_rd advances to the next byte; after the last byte the block returns to the command phase. Host writes in this phase are ignored.
- R10: eng_opcode holds the full opcode byte of the current command, mode bits included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_wdata | input | 8 | Byte written by the host |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_rdata | output | 8 | Current result byte |
| rqm | output | 1 | Ready for a host transfer |
| dio | output | 1 | Transfer direction: 1 means the block presents data to the host |
| eng_start | output | 1 | One-cycle start pulse to the execution engine |
| eng_opcode | output | 8 | Opcode of the current command |
| eng_params | output | 64 | Collected parameter bytes, byte 0 in the low bits |
| eng_done | input | 1 | Engine completion, one cycle |
| eng_results | input | 56 | Engine result bytes, byte 0 in the low bits |

## Verification
Four properties are checked on every cycle by assertions:
- the start pulse lasts exactly one cycle and coincides with ready being low;
- direction high always implies ready high;
- a host write while busy leaves the opcode and parameter outputs unchanged;
- a host read during the command phase does not move the phase.

The other behaviours depend on the command table, so only the bench's directed scenarios can show them. These include the per-opcode parameter and result counts, the constant bytes 0x90 and 0x80, the mode-bit independence of the read command, the byte order of parameters and results, and the return to the command phase after the last byte.

// File: rtl/fdc_phase_seq.sv
`timescale 1ns/1ps
module fdc_phase_seq #(
  parameter int MAX_PARAMS  = 8,
  parameter int MAX_RESULTS = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_wr,
  input  logic [7:0]               host_wdata,
  input  logic                     host_rd,
  output logic [7:0]               host_rdata,
  output logic                     rqm,
  output logic                     dio,
  output logic                     eng_start,
  output logic [7:0]               eng_opcode,
  output logic [8*MAX_PARAMS-1:0]  eng_params,
  input  logic                     eng_done,
  input  logic [8*MAX_RESULTS-1:0] eng_results
);
  localparam int PW = $clog2(MAX_PARAMS + 1);
  localparam int RW = $clog2(MAX_RESULTS + 1);

  typedef enum logic [1:0] {S_CMD, S_PARAM, S_EXEC, S_RES} state_t;
  state_t st;

  logic [PW-1:0] par_need, par_cnt, dec_np;
  logic [RW-1:0] res_need, res_idx, dec_nr;
  logic          dec_ex, start_q;
  logic [7:0]    dec_cb;
  logic [8*MAX_RESULTS-1:0] res_q;

  always_comb begin
    dec_np = '0;
    dec_nr = RW'(1);
    dec_ex = 1'b0;
    dec_cb = 8'h80;
    if (host_wdata[4:0] == 5'b00110) begin
      dec_np = PW'(8);
      dec_nr = RW'(7);
      dec_ex = 1'b1;
    end else begin
      case (host_wdata)
        8'h10: dec_cb = 8'h90;
        8'h08: begin dec_nr = RW'(2); dec_ex = 1'b1; end
        8'h03, 8'h0F, 8'h8F, 8'hCF: begin dec_np = PW'(2); dec_nr = '0; dec_ex = 1'b1; end
        8'h07: begin dec_np = PW'(1); dec_nr = '0; dec_ex = 1'b1; end
        8'h13: begin dec_np = PW'(3); dec_nr = '0; dec_ex = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_CMD;
      start_q    <= 1'b0;
      par_need   <= '0;
      par_cnt    <= '0;
      res_need   <= '0;
      res_idx    <= '0;
      res_q      <= '0;
      eng_opcode <= '0;
      eng_params <= '0;
    end else begin
      start_q <= 1'b0;
      case (st)
        S_CMD: if (host_wr) begin
          eng_opcode <= host_wdata;
          par_need   <= dec_np;
          res_need   <= dec_nr;
          par_cnt    <= '0;
          res_idx    <= '0;
          res_q      <= (8*MAX_RESULTS)'(dec_cb);
          if (dec_np != '0) st <= S_PARAM;
          else if (dec_ex) begin st <= S_EXEC; start_q <= 1'b1; end
          else st <= S_RES;
        end
        S_PARAM: if (host_wr) begin
          eng_params[{par_cnt, 3'b000} +: 8] <= host_wdata;
          par_cnt <= par_cnt + 1'b1;
          if (PW'(par_cnt + 1'b1) == par_need) begin
            st <= S_EXEC;
            start_q <= 1'b1;
          end
        end
        S_EXEC: if (eng_done) begin
          res_q   <= eng_results;
          res_idx <= '0;
          st      <= (res_need != '0) ? S_RES : S_CMD;
        end
        S_RES: if (host_rd) begin
          if (RW'(res_idx + 1'b1) == res_need) st <= S_CMD;
          else res_idx <= res_idx + 1'b1;
        end
        default: st <= S_CMD;
      endcase
    end
  end

  assign eng_start  = start_q;
  assign rqm        = (st != S_EXEC);
  assign dio        = (st == S_RES);
  assign host_rdata = res_q[{res_idx, 3'b000} +: 8];

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !rqm);
  // R9
  dio_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dio |-> rqm);
  // R8
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rqm && host_wr) |=> ($stable(eng_opcode) && $stable(eng_params)));
  // R2
  cmd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rqm && !dio && host_rd && !host_wr) |=> (rqm && !dio));
endmodule

// File: tb/tb_fdc_phase_seq.sv
`timescale 1ns/1ps
module tb_fdc_phase_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, eng_done = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata, eng_opcode;
  logic rqm, dio, eng_start;
  logic [63:0] eng_params;
  logic [55:0] eng_results = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fdc_phase_seq dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .rqm(rqm), .dio(dio),
    .eng_start(eng_start), .eng_opcode(eng_opcode), .eng_params(eng_params),
    .eng_done(eng_done), .eng_results(eng_results));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); host_wdata = b; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd_expect(input string tag, input logic [7:0] exp);
    chk(tag, {63'd0, dio}, 64'd1);
    chk(tag, {56'd0, host_rdata}, {56'd0, exp});
    host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic finish_exec(input logic [55:0] r);
    repeat (3) @(negedge clk);
    eng_results = r; eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rqm", {63'd0, rqm}, 64'd1);
    chk("R1 dio", {63'd0, dio}, 64'd0);
    chk("R1 start", {63'd0, eng_start}, 64'd0);
    host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
    chk("R2 read ignored in cmd phase", {62'd0, rqm, dio}, 64'd2);
  endtask

  task automatic t_read(input logic [7:0] op);
    logic [55:0] res;
    res = 56'hC6_B5_A4_93_82_71_60;
    wr(op);
    chk("R2 accepting params", {62'd0, rqm, dio}, 64'd2);
    for (int i = 0; i < 8; i++) begin
      if (i > 0) chk("R3 still in params", {63'd0, rqm}, 64'd1);
      wr(8'h10 + 8'(i));
    end
    chk("R8 start pulse", {63'd0, eng_start}, 64'd1);
    chk("R8 busy", {63'd0, rqm}, 64'd0);
    chk("R10 opcode", {56'd0, eng_opcode}, {56'd0, op});
    chk("R3 params order", eng_params, 64'h17161514_13121110);
    @(negedge clk);
    chk("R8 pulse ends", {63'd0, eng_start}, 64'd0);
    wr(8'hAA);
    chk("R8 write ignored params", eng_params, 64'h17161514_13121110);
    chk("R8 write ignored opcode", {56'd0, eng_opcode}, {56'd0, op});
    chk("R8 still busy", {63'd0, rqm}, 64'd0);
    finish_exec(res);
    chk("R9 result ready", {62'd0, rqm, dio}, 64'd3);
    wr(8'h33);
    chk("R9 write ignored", {56'd0, host_rdata}, {56'd0, res[7:0]});
    for (int i = 0; i < 7; i++) rd_expect("R3 result byte", res[8*i +: 8]);
    chk("R9 back to cmd", {62'd0, rqm, dio}, 64'd2);
  endtask

  task automatic t_version();
    wr(8'h10);
    chk("R4 no start", {63'd0, eng_start}, 64'd0);
    rd_expect("R4 version byte", 8'h90);
    chk("R4 back to cmd", {62'd0, rqm, dio}, 64'd2);
  endtask

  task automatic t_undef(input logic [7:0] op);
    wr(op);
    chk("R7 no start", {63'd0, eng_start}, 64'd0);
    rd_expect("R7 invalid byte", 8'h80);
    chk("R7 back to cmd", {62'd0, rqm, dio}, 64'd2);
  endtask

  task automatic t_sense();
    wr(8'h08);
    chk("R5 start", {63'd0, eng_start}, 64'd1);
    finish_exec(56'h05_20);
    rd_expect("R5 st0", 8'h20);
    rd_expect("R5 cylinder", 8'h05);
    chk("R5 back to cmd", {62'd0, rqm, dio}, 64'd2);
  endtask

  task automatic t_nores(input logic [7:0] op, input int n);
    logic [63:0] expp;
    expp = eng_params;
    wr(op);
    for (int i = 0; i < n; i++) begin
      chk("R6 accepting param", {62'd0, rqm, dio}, 64'd2);
      chk("R6 no early start", {63'd0, eng_start}, 64'd0);
      wr(8'h40 + 8'(i));
      expp[8*i +: 8] = 8'h40 + 8'(i);
    end
    chk("R6 start", {63'd0, eng_start}, 64'd1);
    chk("R6 params", eng_params, expp);
    chk("R10 opcode", {56'd0, eng_opcode}, {56'd0, op});
    finish_exec(56'hFF);
    chk("R6 no result phase", {62'd0, rqm, dio}, 64'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(8'h06);
    t_read(8'hE6);
    t_read(8'h46);
    t_version();
    t_undef(8'h1F);
    t_undef(8'h8E);
    t_sense();
    t_nores(8'h03, 2);
    t_nores(8'h0F, 2);
    t_nores(8'h07, 1);
    t_nores(8'h13, 3);
    t_nores(8'h8F, 2);
    t_nores(8'hCF, 2);
    t_version();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule